// File: doc/BRIEF.md
# Serial Port Status and Exception Interrupts

This block keeps the status and exception-interrupt state of a synchronous serial port that has one receiver and several transmitters. It tracks the receiver's data-full and overrun flags and a per-transmitter data-empty flag. It also tracks a shared underrun flag. The enabled transmitters' empty flags are summarised as one status bit. The block drives one transmit and one receive exception interrupt, each gated by its own enable bit. An exception flag clears only through a two-step sequence: first a status read, then the data-register access that matches the flag.

The block also publishes a serial input flag taken from an auxiliary pin. The pin is latched on the first received bit after a frame sync. The flag takes the latched value only when a received word moves from the shift register to the data register. The flag is live only in one pin configuration; in every other configuration it reads as zero.

The surrounding port supplies single-cycle event strobes: frame sync, bit clock, receive transfer, transmit load, status read, receive-data read and per-transmitter data writes. It also supplies the mode bits. The shift registers and clock generation are outside this block.

Top module: `serial_port_status`

## Requirements
- R1: `status` is 24 bits wide with this layout: bit 0 input flag, bit 1 transmit-empty, bit 2 underrun, bit 3 receive-full, bit 4 overrun. Bits 23:5 always read 0. After any reset, every transmitter's data register is empty, so bit 1 is 1 exactly when at least one bit of `tx_en` is set.
- R2: `tx_exc_irq` is a registered copy, one cycle late, of (transmit enable bit AND status bit 1 AND status bit 2).
- R3: `rx_exc_irq` is a registered copy, one cycle late, of (receive enable bit AND status bit 3 AND status bit 4).
- R4: A `tx_load` sets the underrun flag if any enabled transmitter is empty at that moment. The load then marks every enabled transmitter empty. A `tx_wr` bit marks its transmitter full, and a write wins over a load in the same cycle.
- R5: `rx_xfer` sets receive-full. `rx_rd` clears it. Overrun sets when `rx_xfer` arrives while receive-full is 1 and no `rx_rd` occurs in the same cycle.
- R6: Underrun clears only after a `sr_rd` that is followed, in later cycles, by writes to every enabled transmitter. Writes made without a prior status read leave the flag set.
- R7: Overrun clears only when `rx_rd` comes in a cycle after a `sr_rd`. A receive read without a prior status read leaves the flag set.
- R8: Each status read re-arms the clearing sequence and discards writes collected so far. If the flag sets again before the sequence completes, the sequence is dropped and needs a new status read.
- R9: The two exception enable bits are loaded by `cfg_wr`. They are cleared by `rst` and `sw_rst`, and they survive `port_rst` and `stop_rst`.
- R10: The first `bclk_evt` after `fs_evt` latches `aux_pin`; a `bclk_evt` in the same cycle as `fs_evt` counts as that first bit. Later bits in the frame are ignored. Status bit 0 takes the latched value only on `rx_xfer`.
- R11: Status bit 0 reads 0 unless all four hold: `aux_is_port`=1, `sync_mode`=1, `tx_en[1]`=0 and `aux_dir_out`=0.
- R12: `rst`, `sw_rst`, `port_rst` and `stop_rst` each clear the input flag, receive-full, overrun and underrun, and each marks all transmitters empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset |
| port_rst | input | 1 | Port-individual reset |
| stop_rst | input | 1 | Stop-mode reset |
| cfg_wr | input | 1 | Load the two exception enable bits |
| cfg_tx_exc_en | input | 1 | Transmit exception enable value |
| cfg_rx_exc_en | input | 1 | Receive exception enable value |
| sync_mode | input | 1 | Synchronous mode selected |
| aux_is_port | input | 1 | Auxiliary pin assigned to the serial port |
| aux_dir_out | input | 1 | Auxiliary pin driven as output |
| tx_en | input | NUM_TX | Transmitter enables |
| fs_evt | input | 1 | Frame sync detected |
| bclk_evt | input | 1 | Receive bit sampled |
| aux_pin | input | 1 | Auxiliary pin level |
| rx_xfer | input | 1 | Receive shift-to-data transfer |
| tx_load | input | 1 | Transmit data-to-shift load due |
| sr_rd | input | 1 | Status register read |
| rx_rd | input | 1 | Receive data register read |
| tx_wr | input | NUM_TX | Per-transmitter data register write |
| status | output | STATUS_W | Status word |
| tx_exc_irq | output | 1 | Transmit exception interrupt |
| rx_exc_irq | output | 1 | Receive exception interrupt |

## Verification
The hardest state to reach from the ports is a clearing sequence that is part done: the status read has been seen and only some of the required writes have arrived. In that state the flag must either survive a re-arming status read or survive being set again. The bench reaches it with the transmitter writes spread one per cycle after the status read. It sweeps every non-zero transmitter enable pattern, and it places a second status read or a fresh underrun between the partial writes. The input flag is swept over all sixteen pin configurations. In each one, the pin changes on the second bit so that publishing the first-bit value, and only on transfer, is visible.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int BIT_IF  = 0;
  localparam int BIT_TDE = 1;
  localparam int BIT_TUE = 2;
  localparam int BIT_RDF = 3;
  localparam int BIT_ROE = 4;
  localparam int FLAG_BITS = 5;
endpackage

// File: rtl/sps_tx_track.sv
module sps_tx_track #(
  parameter int NUM_TX = 3
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [NUM_TX-1:0] tx_en,
  input  logic              tx_load,
  input  logic [NUM_TX-1:0] tx_wr,
  input  logic              sr_rd,
  output logic              tde,
  output logic              tue
);
  logic [NUM_TX-1:0] empty_q;
  logic [NUM_TX-1:0] seen_q;
  logic              tue_q;
  logic              armed_q;
  logic              underrun_hit;
  logic              wr_done;

  // per-transmitter data register occupancy
  for (genvar i = 0; i < NUM_TX; i++) begin : g_empty
    always_ff @(posedge clk) begin
      if (clr)                      empty_q[i] <= 1'b1;
      else if (tx_wr[i])            empty_q[i] <= 1'b0;
      else if (tx_load && tx_en[i]) empty_q[i] <= 1'b1;
    end
  end

  assign underrun_hit = tx_load && |(empty_q & tx_en);
  assign wr_done = armed_q && !sr_rd && |(tx_wr & tx_en) &&
                   (((seen_q | tx_wr) & tx_en) == tx_en);

  always_ff @(posedge clk) begin
    if (clr) begin
      tue_q   <= 1'b0;
      armed_q <= 1'b0;
      seen_q  <= '0;
    end else if (underrun_hit) begin
      tue_q   <= 1'b1;
      armed_q <= 1'b0;
      seen_q  <= '0;
    end else if (sr_rd) begin
      armed_q <= 1'b1;
      seen_q  <= '0;
    end else if (wr_done) begin
      tue_q   <= 1'b0;
      armed_q <= 1'b0;
      seen_q  <= '0;
    end else if (armed_q) begin
      seen_q  <= seen_q | tx_wr;
    end
  end

  assign tde = |(empty_q & tx_en);
  assign tue = tue_q;
endmodule

// File: rtl/sps_rx_track.sv
module sps_rx_track (
  input  logic clk,
  input  logic clr,
  input  logic rx_xfer,
  input  logic rx_rd,
  input  logic sr_rd,
  output logic rdf,
  output logic roe
);
  logic rdf_q, roe_q, armed_q;
  logic ovr_hit;

  assign ovr_hit = rx_xfer && rdf_q && !rx_rd;

  always_ff @(posedge clk) begin
    if (clr)          rdf_q <= 1'b0;
    else if (rx_xfer) rdf_q <= 1'b1;
    else if (rx_rd)   rdf_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      roe_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (ovr_hit) begin
      roe_q   <= 1'b1;
      armed_q <= 1'b0;
    end else if (sr_rd) begin
      armed_q <= 1'b1;
    end else if (armed_q && rx_rd) begin
      roe_q   <= 1'b0;
      armed_q <= 1'b0;
    end
  end

  assign rdf = rdf_q;
  assign roe = roe_q;
endmodule

// File: rtl/sps_iflag.sv
module sps_iflag (
  input  logic clk,
  input  logic clr,
  input  logic enable,
  input  logic fs_evt,
  input  logic bclk_evt,
  input  logic pin,
  input  logic rx_xfer,
  output logic iflag
);
  logic pend_q, latch_q, if_q;
  logic take;

  assign take = bclk_evt && (pend_q || fs_evt);

  always_ff @(posedge clk) begin
    if (clr) begin
      pend_q  <= 1'b0;
      latch_q <= 1'b0;
    end else if (take) begin
      pend_q  <= 1'b0;
      latch_q <= pin;
    end else if (fs_evt) begin
      pend_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clr || !enable) if_q <= 1'b0;
    else if (rx_xfer)   if_q <= latch_q;
  end

  assign iflag = if_q;
endmodule

// File: rtl/serial_port_status.sv
module serial_port_status #(
  parameter int NUM_TX   = 3,
  parameter int STATUS_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_rst,
  input  logic                port_rst,
  input  logic                stop_rst,
  input  logic                cfg_wr,
  input  logic                cfg_tx_exc_en,
  input  logic                cfg_rx_exc_en,
  input  logic                sync_mode,
  input  logic                aux_is_port,
  input  logic                aux_dir_out,
  input  logic [NUM_TX-1:0]   tx_en,
  input  logic                fs_evt,
  input  logic                bclk_evt,
  input  logic                aux_pin,
  input  logic                rx_xfer,
  input  logic                tx_load,
  input  logic                sr_rd,
  input  logic                rx_rd,
  input  logic [NUM_TX-1:0]   tx_wr,
  output logic [STATUS_W-1:0] status,
  output logic                tx_exc_irq,
  output logic                rx_exc_irq
);
  import sps_pkg::*;

  logic any_clr, ie_clr;
  logic txie_q, rxie_q;
  logic tx_irq_q, rx_irq_q;
  logic tde, tue, rdf, roe, iflag;
  logic tx1_on, if_en;

  assign any_clr = rst || sw_rst || port_rst || stop_rst;
  assign ie_clr  = rst || sw_rst;

  if (NUM_TX > 1) begin : g_tx1
    assign tx1_on = tx_en[1];
  end else begin : g_no_tx1
    assign tx1_on = 1'b0;
  end

  assign if_en = aux_is_port && sync_mode && !tx1_on && !aux_dir_out;

  sps_tx_track #(.NUM_TX(NUM_TX)) u_tx (
    .clk(clk), .clr(any_clr), .tx_en(tx_en), .tx_load(tx_load),
    .tx_wr(tx_wr), .sr_rd(sr_rd), .tde(tde), .tue(tue)
  );

  sps_rx_track u_rx (
    .clk(clk), .clr(any_clr), .rx_xfer(rx_xfer), .rx_rd(rx_rd),
    .sr_rd(sr_rd), .rdf(rdf), .roe(roe)
  );

  sps_iflag u_if (
    .clk(clk), .clr(any_clr), .enable(if_en), .fs_evt(fs_evt),
    .bclk_evt(bclk_evt), .pin(aux_pin), .rx_xfer(rx_xfer), .iflag(iflag)
  );

  always_ff @(posedge clk) begin
    if (ie_clr) begin
      txie_q <= 1'b0;
      rxie_q <= 1'b0;
    end else if (cfg_wr) begin
      txie_q <= cfg_tx_exc_en;
      rxie_q <= cfg_rx_exc_en;
    end
  end

  always_ff @(posedge clk) begin
    if (any_clr) begin
      tx_irq_q <= 1'b0;
      rx_irq_q <= 1'b0;
    end else begin
      tx_irq_q <= txie_q && tde && tue;
      rx_irq_q <= rxie_q && rdf && roe;
    end
  end

  always_comb begin
    status          = '0;
    status[BIT_IF]  = iflag;
    status[BIT_TDE] = tde;
    status[BIT_TUE] = tue;
    status[BIT_RDF] = rdf;
    status[BIT_ROE] = roe;
  end

  assign tx_exc_irq = tx_irq_q;
  assign rx_exc_irq = rx_irq_q;
endmodule

// File: rtl/sps_status_chk.sv
module sps_status_chk #(
  parameter int NUM_TX   = 3,
  parameter int STATUS_W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                sw_rst,
  input logic                port_rst,
  input logic                stop_rst,
  input logic                sync_mode,
  input logic                aux_is_port,
  input logic                aux_dir_out,
  input logic [NUM_TX-1:0]   tx_en,
  input logic                rx_xfer,
  input logic                rx_rd,
  input logic [NUM_TX-1:0]   tx_wr,
  input logic [STATUS_W-1:0] status,
  input logic                tx_exc_irq,
  input logic                rx_exc_irq
);
  import sps_pkg::*;

  logic soft_clr;
  assign soft_clr = sw_rst || port_rst || stop_rst;

  // R2: transmit interrupt only follows a cycle with empty and underrun both set
  p_txirq_src_r2: assert property (@(posedge clk) disable iff (rst)
    tx_exc_irq |-> $past(status[BIT_TUE] && status[BIT_TDE]));

  // R3: receive interrupt only follows a cycle with full and overrun both set
  p_rxirq_src_r3: assert property (@(posedge clk) disable iff (rst)
    rx_exc_irq |-> $past(status[BIT_ROE] && status[BIT_RDF]));

  // R5: transfer into a full receive register raises overrun
  p_ovr_set_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_xfer && status[BIT_RDF] && !rx_rd && !soft_clr) |=> status[BIT_ROE]);

  // R6: underrun falls only on a transmitter write or a reset
  p_tue_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(status[BIT_TUE]) |-> ($past(|tx_wr) || $past(soft_clr) || $past(rst)));

  // R7: overrun falls only on a receive read or a reset
  p_roe_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(status[BIT_ROE]) |-> ($past(rx_rd) || $past(soft_clr) || $past(rst)));

  // R11: input flag off in any configuration but the single enabled one
  p_if_off_r11: assert property (@(posedge clk) disable iff (rst)
    !(aux_is_port && sync_mode && !tx_en[1] && !aux_dir_out) |=> !status[BIT_IF]);
endmodule

bind serial_port_status sps_status_chk #(.NUM_TX(NUM_TX), .STATUS_W(STATUS_W)) u_chk (
  .clk(clk), .rst(rst), .sw_rst(sw_rst), .port_rst(port_rst), .stop_rst(stop_rst),
  .sync_mode(sync_mode), .aux_is_port(aux_is_port), .aux_dir_out(aux_dir_out),
  .tx_en(tx_en), .rx_xfer(rx_xfer), .rx_rd(rx_rd), .tx_wr(tx_wr),
  .status(status), .tx_exc_irq(tx_exc_irq), .rx_exc_irq(rx_exc_irq)
);

// File: tb/serial_port_status_bench.sv
module serial_port_status_bench;
  localparam int NT = 3;
  localparam int SW = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, sw_rst = 1'b0, port_rst = 1'b0, stop_rst = 1'b0;
  logic cfg_wr = 1'b0, cfg_tx_exc_en = 1'b0, cfg_rx_exc_en = 1'b0;
  logic sync_mode = 1'b0, aux_is_port = 1'b0, aux_dir_out = 1'b0;
  logic [NT-1:0] tx_en = 3'b111;
  logic fs_evt = 1'b0, bclk_evt = 1'b0, aux_pin = 1'b0;
  logic rx_xfer = 1'b0, tx_load = 1'b0, sr_rd = 1'b0, rx_rd = 1'b0;
  logic [NT-1:0] tx_wr = '0;
  logic [SW-1:0] status;
  logic tx_exc_irq, rx_exc_irq;

  serial_port_status #(.NUM_TX(NT), .STATUS_W(SW)) u_serial_port_status (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .port_rst(port_rst), .stop_rst(stop_rst),
    .cfg_wr(cfg_wr), .cfg_tx_exc_en(cfg_tx_exc_en), .cfg_rx_exc_en(cfg_rx_exc_en),
    .sync_mode(sync_mode), .aux_is_port(aux_is_port), .aux_dir_out(aux_dir_out),
    .tx_en(tx_en), .fs_evt(fs_evt), .bclk_evt(bclk_evt), .aux_pin(aux_pin),
    .rx_xfer(rx_xfer), .tx_load(tx_load), .sr_rd(sr_rd), .rx_rd(rx_rd),
    .tx_wr(tx_wr), .status(status), .tx_exc_irq(tx_exc_irq), .rx_exc_irq(rx_exc_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic exp_if;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R1: upper status bits must stay zero on every status check
  task automatic chk_bit(input string tag, input int pos, input logic exp);
    chk(tag, {31'd0, status[pos]}, {31'd0, exp});
    if (status[SW-1:5] !== '0) chk("R1 upper bits zero", {8'd0, status}, {8'd0, 19'd0, status[4:0]});
  endtask

  task automatic step;
    @(negedge clk);
    tx_wr = '0; tx_load = 0; sr_rd = 0; rx_xfer = 0; rx_rd = 0;
    fs_evt = 0; bclk_evt = 0; cfg_wr = 0; sw_rst = 0; port_rst = 0; stop_rst = 0;
  endtask

  task automatic set_ie(input logic t, input logic r);
    cfg_wr = 1; cfg_tx_exc_en = t; cfg_rx_exc_en = r; step;
  endtask

  task automatic make_ovr;
    rx_xfer = 1; step; rx_xfer = 1; step; step;
  endtask

  task automatic capture(input logic v);
    fs_evt = 1; step; aux_pin = v; bclk_evt = 1; step;
    rx_xfer = 1; step; rx_rd = 1; step;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step;
    // R1: reset layout with all transmitters enabled
    chk("R1 reset status", {8'd0, status}, 32'h2);
    chk("R2 reset tx irq", {31'd0, tx_exc_irq}, 0);
    chk("R3 reset rx irq", {31'd0, rx_exc_irq}, 0);
    tx_en = '0; step;
    chk("R1 TDE with no transmitter", {8'd0, status}, 32'h0);

    set_ie(1, 1);

    // R4 R6 R2: sweep every enable pattern
    for (int en = 1; en < 8; en++) begin
      logic [2:0] e;
      e = en[2:0];
      tx_en = e;
      tx_wr = 3'b111; step;
      tx_load = 1; step;
      chk_bit("R4 no underrun when full", 2, 0);
      chk_bit("R4 load empties", 1, 1);
      tx_load = 1; step;
      chk_bit("R4 underrun set", 2, 1);
      step;
      chk("R2 tx irq raised", {31'd0, tx_exc_irq}, 1);
      tx_wr = e; step;
      chk_bit("R6 writes without read keep underrun", 2, 1);
      chk_bit("R4 write fills", 1, 0);
      step;
      chk("R2 tx irq follows empty", {31'd0, tx_exc_irq}, 0);
      sr_rd = 1; step;
      for (int i = 0; i < 3; i++) begin
        if (e[i]) begin
          logic [2:0] rest;
          rest = e & ~3'((2 << i) - 1);
          tx_wr = 3'(1 << i); step;
          chk_bit("R6 partial then full write clear", 2, rest != 0);
        end
      end
    end

    // R8: re-arm discards collected writes
    tx_en = 3'b011;
    tx_load = 1; step; tx_load = 1; step;
    chk_bit("R4 underrun for R8", 2, 1);
    sr_rd = 1; step; tx_wr = 3'b001; step;
    sr_rd = 1; step; tx_wr = 3'b010; step;
    chk_bit("R8 re-arm restarts collection", 2, 1);
    tx_wr = 3'b001; step;
    chk_bit("R8 clear after re-arm", 2, 0);
    // R8: fresh underrun drops the sequence
    tx_load = 1; step; tx_load = 1; step;
    sr_rd = 1; step; tx_wr = 3'b001; step;
    tx_load = 1; step;
    tx_wr = 3'b011; step;
    chk_bit("R8 underrun again drops sequence", 2, 1);
    sr_rd = 1; step; tx_wr = 3'b011; step;
    chk_bit("R8 clear after new read", 2, 0);

    // R5 R7 R3 R8: receive side
    rx_xfer = 1; step;
    chk_bit("R5 full set", 3, 1);
    chk_bit("R5 no overrun on first", 4, 0);
    rx_xfer = 1; step;
    chk_bit("R5 overrun set", 4, 1);
    step;
    chk("R3 rx irq raised", {31'd0, rx_exc_irq}, 1);
    rx_rd = 1; step;
    chk_bit("R5 read clears full", 3, 0);
    chk_bit("R7 read without status read keeps overrun", 4, 1);
    step;
    chk("R3 rx irq follows full", {31'd0, rx_exc_irq}, 0);
    rx_xfer = 1; step;
    sr_rd = 1; step;
    rx_xfer = 1; step;
    rx_rd = 1; step;
    chk_bit("R8 overrun again drops sequence", 4, 1);
    rx_xfer = 1; step;
    sr_rd = 1; step; rx_rd = 1; step;
    chk_bit("R7 read after status read clears", 4, 0);
    rx_xfer = 1; step;
    rx_xfer = 1; rx_rd = 1; step;
    chk_bit("R5 same-cycle read avoids overrun", 4, 0);
    chk_bit("R5 full stays", 3, 1);
    rx_rd = 1; step;

    // R9 R12: which resets reach the enables
    make_ovr;
    chk("R9 rx irq before resets", {31'd0, rx_exc_irq}, 1);
    port_rst = 1; step;
    chk("R12 port reset clears flags", {8'd0, status}, 32'h2);
    make_ovr;
    chk("R9 enable survives port reset", {31'd0, rx_exc_irq}, 1);
    stop_rst = 1; step;
    chk("R12 stop reset clears flags", {8'd0, status}, 32'h2);
    make_ovr;
    chk("R9 enable survives stop reset", {31'd0, rx_exc_irq}, 1);
    sw_rst = 1; step;
    chk("R12 soft reset clears flags", {8'd0, status}, 32'h2);
    make_ovr;
    chk("R9 soft reset clears enable", {31'd0, rx_exc_irq}, 0);
    set_ie(1, 1);
    rst = 1; step; rst = 0; step;
    make_ovr;
    chk("R9 hardware reset clears enable", {31'd0, rx_exc_irq}, 0);
    rx_rd = 1; step;
    set_ie(1, 1);

    // R10 R11: every pin configuration
    exp_if = 0;
    for (int c = 0; c < 16; c++) begin
      logic ena;
      aux_is_port = c[0]; sync_mode = c[1]; tx_en = {1'b0, c[2], 1'b1}; aux_dir_out = c[3];
      ena = (c == 3);
      step;
      if (!ena) exp_if = 0;
      chk_bit("R11 flag after config", 0, exp_if);
      for (int v = 1; v >= 0; v--) begin
        fs_evt = 1; step;
        aux_pin = v[0]; bclk_evt = 1; step;
        aux_pin = !v[0]; bclk_evt = 1; step;
        chk_bit("R10 held until transfer", 0, exp_if);
        rx_xfer = 1; step;
        exp_if = ena ? v[0] : 1'b0;
        chk_bit("R10 R11 first bit published", 0, exp_if);
        rx_rd = 1; step;
      end
    end

    // R10: frame sync and first bit in one cycle
    aux_is_port = 1; sync_mode = 1; tx_en = 3'b001; aux_dir_out = 0;
    fs_evt = 1; bclk_evt = 1; aux_pin = 1; step;
    aux_pin = 0; bclk_evt = 1; step;
    rx_xfer = 1; step;
    chk_bit("R10 same-cycle sync and bit", 0, 1);
    rx_rd = 1; step;

    // R12: every reset clears the input flag
    port_rst = 1; step;
    chk_bit("R12 port reset clears flag", 0, 0);
    capture(1);
    chk_bit("R10 flag recaptured", 0, 1);
    stop_rst = 1; step;
    chk_bit("R12 stop reset clears flag", 0, 0);
    capture(1);
    sw_rst = 1; step;
    chk_bit("R12 soft reset clears flag", 0, 0);
    capture(1);
    rst = 1; step; rst = 0; step;
    chk_bit("R12 hardware reset clears flag", 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule